// File: doc/BRIEF.md
# Endpoint DMA Handshake Engine

This block sits between an external DMA controller and one endpoint's packet buffer. It moves payload bytes in either direction with a request/acknowledge handshake. The engine raises a request when the buffer can take or supply a burst. The DMA controller answers with an active-low acknowledge and then pulses an active-low read or write strobe for each byte. The engine counts the bytes within a packet. It addresses the buffer past the two-byte packet header, and it tells the buffer side when a packet has been filled or fully drained.

A single byte of configuration sets the burst size, the enable, the direction and auto-reload. An active-low end-of-transfer input from the DMA controller stops the engine early. It clears the enable, marks a partly written packet as valid and raises a sticky flag that the interrupt logic reads and clears. With auto-reload set, the engine carries on with the next packet without software. With auto-reload clear, it drops its enable after each packet.

The four handshake inputs arrive from another clock domain. Each passes through a two-stage synchronizer, so every edge takes effect two or three clock cycles after it reaches the pins.

Top module: `ep_dma_engine`

## Requirements
- R1: After reset, dmaReq, eotFlag, bufValidate, bufRelease and bufWrStrobe are low, cfgRdData reads 0x00 and bufAddr reads 2.
- R2: cfgWrEn loads cfgWrData into the configuration byte. Bits [1:0] are the burst code, bit 2 is enable, bit 3 is direction (0 = buffer to memory, 1 = memory to buffer) and bit 4 is auto-reload. Bits [7:5] are kept. cfgRdData returns the whole byte, including any enable bit that the engine has cleared.
- R3: dmaReq is high only when enable is set, eot_n is high and the buffer is ready. In direction 0, ready means bufFull is high. In direction 1, ready means bufEmpty is high.
- R4: A request grants a burst of 1, 4, 8 or 16 byte strobes for burst codes 00, 01, 10 and 11. The burst is shortened to the bytes left in the packet. dmaReq falls once the falling edge of the burst's final strobe is seen, and it stays high for the earlier strobes.
- R5: A byte is counted only on a rising edge of the selected strobe (rd_n in direction 0, wr_n in direction 1) while dmaAck_n is low. Edges on the other strobe, and strobes while dmaAck_n is high, leave bufAddr, bufWrStrobe and dmaReq unchanged.
- R6: bufAddr equals 2 plus the index of the current payload byte within the packet, so the reserved byte and the length byte at buffer offsets 0 and 1 are never moved.
- R7: In direction 0, dmaDataOut holds the buffer byte at bufAddr, captured when the falling edge of rd_n is seen. After bufLen bytes, bufRelease pulses for one cycle.
- R8: In direction 1, each counted wr_n edge pulses bufWrStrobe with bufWrData holding the byte captured when the falling edge of wr_n was seen. After MAX_PKT bytes, bufValidate pulses for one cycle.
- R9: A falling edge of eot_n clears enable, sets eotFlag, forces dmaReq low and restarts the byte count. In direction 1 with a partly written packet, it also pulses bufValidate.
- R10: irqRead clears eotFlag. If an end-of-transfer edge arrives in the same cycle, the flag is set instead.
- R11: When a packet completes with auto-reload set, enable stays set and the next packet is requested once the buffer is ready. With auto-reload clear, enable is cleared at packet completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfgWrEn | input | 1 | Configuration byte write strobe |
| cfgWrData | input | 8 | Configuration byte write value |
| cfgRdData | output | 8 | Configuration byte read-back |
| irqRead | input | 1 | Interrupt register read, clears eotFlag |
| eotFlag | output | 1 | Sticky end-of-transfer interrupt flag |
| dmaReq | output | 1 | DMA request |
| dmaAck_n | input | 1 | DMA acknowledge, active low, asynchronous |
| rd_n | input | 1 | DMA read strobe, active low, asynchronous |
| wr_n | input | 1 | DMA write strobe, active low, asynchronous |
| eot_n | input | 1 | End of transfer, active low, asynchronous |
| dmaDataIn | input | 8 | Byte from system memory (direction 1) |
| dmaDataOut | output | 8 | Byte to system memory (direction 0) |
| bufFull | input | 1 | Buffer holds a received packet |
| bufEmpty | input | 1 | Buffer has a free packet slot |
| bufLen | input | $clog2(MAX_PKT+1) | Payload length of the packet being read |
| bufAddr | output | $clog2(MAX_PKT+2) | Buffer byte offset of the current payload byte |
| bufRdData | input | 8 | Buffer byte at bufAddr |
| bufWrData | output | 8 | Byte to write at bufAddr |
| bufWrStrobe | output | 1 | Write bufWrData at bufAddr |
| bufValidate | output | 1 | Written packet is complete |
| bufRelease | output | 1 | Read packet is fully drained |

## Verification
Reads are swept over every burst code against every packet length from 1 to the maximum. This separates a burst cut short by the packet end from a full burst, and it shows whether the release pulse lands on the last byte rather than the last burst. Writes go through every burst code with distinct data seeds. Because each byte value depends on its index, a header offset error or a dropped byte shows up in the data. Further targeted patterns cover the remaining behaviour. Strobes on the wrong line or without acknowledge must not be counted. An end-of-transfer edge in mid-burst is timed to coincide with a flag read. A packet run with auto-reload clear must leave the engine disabled.

// File: rtl/ep_dma_pkg.sv
package ep_dma_pkg;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } dmaState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic latchRd;   // capture the buffer byte for the memory side
    logic latchWr;   // capture the memory byte for the buffer side
    logic advance;   // step to the next payload byte
    logic restart;   // packet finished or aborted, back to byte 0
  } pathCmd_t;

  function automatic logic [4:0] burstSize(input logic [1:0] code);
    case (code)
      2'b00:   burstSize = 5'd1;
      2'b01:   burstSize = 5'd4;
      2'b10:   burstSize = 5'd8;
      default: burstSize = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/ep_dma_sync.sv
module ep_dma_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  logic [W-1:0] stage1;

  // idle level of every handshake line is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1  <= '1;
      syncOut <= '1;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/ep_dma_path.sv
module ep_dma_path
  import ep_dma_pkg::*;
#(
  parameter  int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = $clog2(MAX_PKT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pathCmd_t      cmd,
  input  logic [7:0]    dmaDataIn,
  input  logic [7:0]    bufRdData,
  output logic [CW-1:0] count,
  output logic [AW-1:0] bufAddr,
  output logic [7:0]    dmaDataOut,
  output logic [7:0]    bufWrData
);

  localparam int HDR_BYTES = 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      dmaDataOut <= '0;
      bufWrData  <= '0;
    end else begin
      if (cmd.restart)      count <= '0;
      else if (cmd.advance) count <= count + CW'(1);
      if (cmd.latchRd) dmaDataOut <= bufRdData;
      if (cmd.latchWr) bufWrData  <= dmaDataIn;
    end
  end

  // payload starts after the reserved byte and the length byte
  assign bufAddr = AW'(count) + AW'(HDR_BYTES);

  // R6 the index restarts on the last byte, so it never reaches the packet size
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count < CW'(MAX_PKT));

  // R6 restart wins over advance: the index returns to zero
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.restart |=> (count == '0));

endmodule

// File: rtl/ep_dma_ctrl.sv
module ep_dma_ctrl
  import ep_dma_pkg::*;
#(
  parameter  int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfgWrEn,
  input  logic [7:0]    cfgWrData,
  output logic [7:0]    cfgRdData,
  input  logic          irqRead,
  output logic          eotFlag,
  input  logic          ackS_n,
  input  logic          rdS_n,
  input  logic          wrS_n,
  input  logic          eotS_n,
  input  logic          bufFull,
  input  logic          bufEmpty,
  input  logic [CW-1:0] bufLen,
  input  logic [CW-1:0] count,
  output logic          dmaReq,
  output pathCmd_t      cmd,
  output logic          bufWrStrobe,
  output logic          bufValidate,
  output logic          bufRelease
);

  localparam int LW = (CW > 5) ? CW : 5;

  dmaState_t    state;
  logic [1:0]   cfgBurst;
  logic         cfgEn, cfgDir, cfgReload;
  logic [2:0]   cfgSpare;
  logic [LW-1:0] burstLeft, burstLoad, burstCap, remainW;
  logic         lastBegun, rdPrev, wrPrev, eotPrev;
  logic         inBurst, selNow, selPrev, strobeFall, strobeRise, eotFall;
  logic         lastByte, ready, start, pktDone;
  logic [CW-1:0] pktLen, remaining;

  always_comb begin
    inBurst    = (state == ST_BURST);
    selNow     = cfgDir ? wrS_n  : rdS_n;
    selPrev    = cfgDir ? wrPrev : rdPrev;
    strobeFall = inBurst && !ackS_n && selPrev && !selNow;
    strobeRise = inBurst && !ackS_n && !selPrev && selNow;
    eotFall    = eotPrev && !eotS_n;
    pktLen     = cfgDir ? CW'(MAX_PKT) : bufLen;
    remaining  = pktLen - count;
    lastByte   = (count + CW'(1)) == pktLen;
    ready      = cfgDir ? bufEmpty : bufFull;
    start      = !inBurst && cfgEn && ready && eotS_n && (remaining != '0);
    burstCap   = LW'(burstSize(cfgBurst));
    remainW    = LW'(remaining);
    burstLoad  = (burstCap < remainW) ? burstCap : remainW;
    pktDone    = strobeRise && lastByte;
  end

  // request / burst sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      burstLeft <= '0;
      lastBegun <= 1'b0;
      rdPrev    <= 1'b1;
      wrPrev    <= 1'b1;
      eotPrev   <= 1'b1;
    end else begin
      rdPrev  <= rdS_n;
      wrPrev  <= wrS_n;
      eotPrev <= eotS_n;
      if (eotFall || !cfgEn) begin
        state     <= ST_IDLE;
        lastBegun <= 1'b0;
      end else if (start) begin
        state     <= ST_BURST;
        burstLeft <= burstLoad;
        lastBegun <= 1'b0;
      end else if (inBurst) begin
        if (strobeFall && burstLeft == LW'(1)) lastBegun <= 1'b1;
        if (strobeRise) begin
          burstLeft <= burstLeft - LW'(1);
          if (burstLeft == LW'(1)) state <= ST_IDLE;
        end
      end
    end
  end

  // configuration byte and end-of-transfer flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cfgSpare, cfgReload, cfgDir, cfgEn, cfgBurst} <= '0;
      eotFlag <= 1'b0;
    end else begin
      if (cfgWrEn) {cfgSpare, cfgReload, cfgDir, cfgEn, cfgBurst} <= cfgWrData;
      if (pktDone && !cfgReload) cfgEn <= 1'b0;
      if (eotFall) cfgEn <= 1'b0;
      if (eotFall)      eotFlag <= 1'b1;
      else if (irqRead) eotFlag <= 1'b0;
    end
  end

  assign cfgRdData   = {cfgSpare, cfgReload, cfgDir, cfgEn, cfgBurst};
  assign dmaReq      = inBurst && !lastBegun && eotS_n && cfgEn;
  assign cmd.latchRd = strobeFall && !cfgDir;
  assign cmd.latchWr = strobeFall && cfgDir;
  assign cmd.advance = strobeRise && !lastByte;
  assign cmd.restart = pktDone || eotFall;
  assign bufWrStrobe = strobeRise && cfgDir;
  assign bufValidate = cfgDir && (pktDone || (eotFall && count != '0));
  assign bufRelease  = !cfgDir && pktDone;

  // R9
  eot_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eotFall |=> (!cfgEn && eotFlag && !dmaReq));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irqRead && !eotFall) |=> !eotFlag);

  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobeFall && burstLeft == LW'(1)) |=> !dmaReq);

  // R4
  burst_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inBurst |-> (burstLeft != '0));

  // R7
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bufValidate, bufRelease}));

  // R11
  reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pktDone && cfgReload && !eotFall && !cfgWrEn) |=> cfgEn);

endmodule

// File: rtl/ep_dma_engine.sv
module ep_dma_engine
  import ep_dma_pkg::*;
#(
  parameter  int MAX_PKT = 64,
  localparam int CW = $clog2(MAX_PKT + 1),
  localparam int AW = $clog2(MAX_PKT + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfgWrEn,
  input  logic [7:0]    cfgWrData,
  output logic [7:0]    cfgRdData,
  input  logic          irqRead,
  output logic          eotFlag,
  output logic          dmaReq,
  input  logic          dmaAck_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          eot_n,
  input  logic [7:0]    dmaDataIn,
  output logic [7:0]    dmaDataOut,
  input  logic          bufFull,
  input  logic          bufEmpty,
  input  logic [CW-1:0] bufLen,
  output logic [AW-1:0] bufAddr,
  input  logic [7:0]    bufRdData,
  output logic [7:0]    bufWrData,
  output logic          bufWrStrobe,
  output logic          bufValidate,
  output logic          bufRelease
);

  logic [3:0]    syncLines;
  logic [CW-1:0] count;
  pathCmd_t      cmd;

  ep_dma_sync #(.W(4)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn ({dmaAck_n, rd_n, wr_n, eot_n}),
    .syncOut (syncLines)
  );

  ep_dma_ctrl #(.MAX_PKT(MAX_PKT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfgWrEn     (cfgWrEn),
    .cfgWrData   (cfgWrData),
    .cfgRdData   (cfgRdData),
    .irqRead     (irqRead),
    .eotFlag     (eotFlag),
    .ackS_n      (syncLines[3]),
    .rdS_n       (syncLines[2]),
    .wrS_n       (syncLines[1]),
    .eotS_n      (syncLines[0]),
    .bufFull     (bufFull),
    .bufEmpty    (bufEmpty),
    .bufLen      (bufLen),
    .count       (count),
    .dmaReq      (dmaReq),
    .cmd         (cmd),
    .bufWrStrobe (bufWrStrobe),
    .bufValidate (bufValidate),
    .bufRelease  (bufRelease)
  );

  ep_dma_path #(.MAX_PKT(MAX_PKT)) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .dmaDataIn  (dmaDataIn),
    .bufRdData  (bufRdData),
    .count      (count),
    .bufAddr    (bufAddr),
    .dmaDataOut (dmaDataOut),
    .bufWrData  (bufWrData)
  );

endmodule

// File: tb/sim_ep_dma_engine.sv
module sim_ep_dma_engine;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_PKT    = 8;
  localparam int CW = $clog2(MAX_PKT + 1);
  localparam int AW = $clog2(MAX_PKT + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic irqRead = 1'b0;
  logic eotFlag, dmaReq;
  logic dmaAck_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, eot_n = 1'b1;
  logic [7:0] dmaDataIn = '0;
  logic [7:0] dmaDataOut;
  logic bufFull = 1'b0;
  logic bufEmpty = 1'b0;
  logic fillPulse = 1'b0;
  logic [CW-1:0] bufLen = '0;
  logic [AW-1:0] bufAddr;
  logic [7:0] bufRdData, bufWrData;
  logic bufWrStrobe, bufValidate, bufRelease;

  int nChecks = 0, nErr = 0;
  int rdSeed = 0, wrSeed = 0;
  int monIdx = 0, wrCount = 0, validCount = 0, releaseCount = 0, lastValidLen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // buffer model: every byte is a function of its buffer offset
  assign bufRdData = 8'(int'(bufAddr) * 7 + rdSeed);

  ep_dma_engine #(.MAX_PKT(MAX_PKT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .irqRead(irqRead), .eotFlag(eotFlag), .dmaReq(dmaReq),
    .dmaAck_n(dmaAck_n), .rd_n(rd_n), .wr_n(wr_n), .eot_n(eot_n),
    .dmaDataIn(dmaDataIn), .dmaDataOut(dmaDataOut), .bufFull(bufFull),
    .bufEmpty(bufEmpty), .bufLen(bufLen), .bufAddr(bufAddr), .bufRdData(bufRdData),
    .bufWrData(bufWrData), .bufWrStrobe(bufWrStrobe), .bufValidate(bufValidate),
    .bufRelease(bufRelease)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wrVal(input int idx);
    return (idx * 13 + wrSeed) % 256;
  endfunction

  function automatic int rdVal(input int idx);
    return ((idx + 2) * 7 + rdSeed) % 256;
  endfunction

  function automatic int burstN(input int code);
    return (code == 0) ? 1 : (2 << code);
  endfunction

  // monitor of the buffer side, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (bufWrStrobe) begin
        checkEq("R6 write offset", int'(bufAddr), monIdx + 2);
        checkEq("R8 write data", int'(bufWrData), wrVal(monIdx));
        monIdx++;
        wrCount++;
      end
      if (bufValidate) begin
        validCount++;
        lastValidLen = monIdx;
        monIdx = 0;
      end
      if (bufRelease) releaseCount++;
      if (bufRelease) bufFull = 1'b0;
      else if (fillPulse) bufFull = 1'b1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(input logic [7:0] v);
    cfgWrEn = 1'b1;
    cfgWrData = v;
    tick(1);
    cfgWrEn = 1'b0;
    tick(1);
  endtask

  task automatic waitReq();
    int t = 0;
    while (!dmaReq && t < 40) begin
      tick(1);
      t++;
    end
    checkEq("R3 request raised", int'(dmaReq), 1);
  endtask

  task automatic doBurst(input int n, input bit isWrite, input int baseIdx);
    waitReq();
    dmaAck_n = 1'b0;
    tick(2);
    for (int i = 0; i < n; i++) begin
      if (isWrite) begin
        dmaDataIn = 8'(wrVal(baseIdx + i));
        wr_n = 1'b0;
      end else begin
        rd_n = 1'b0;
      end
      tick(4);
      checkEq("R4 request during burst", int'(dmaReq), (i == n - 1) ? 0 : 1);
      if (!isWrite) checkEq("R7 R6 read data", int'(dmaDataOut), rdVal(baseIdx + i));
      rd_n = 1'b1;
      wr_n = 1'b1;
      tick(4);
    end
    dmaAck_n = 1'b1;
    tick(2);
  endtask

  task automatic readPacket(input int code, input int len);
    int rem, base, n, relBefore;
    relBefore = releaseCount;
    bufLen = CW'(len);
    rdSeed = len * 5 + code;
    fillPulse = 1'b1;
    tick(1);
    fillPulse = 1'b0;
    rem = len;
    base = 0;
    while (rem > 0) begin
      n = (burstN(code) < rem) ? burstN(code) : rem;
      doBurst(n, 1'b0, base);
      base += n;
      rem -= n;
    end
    tick(4);
    checkEq("R7 release after last byte", releaseCount, relBefore + 1);
  endtask

  task automatic writePacket(input int code, input int seed);
    int rem, base, n, valBefore;
    valBefore = validCount;
    wrSeed = seed;
    rem = MAX_PKT;
    base = 0;
    while (rem > 0) begin
      n = (burstN(code) < rem) ? burstN(code) : rem;
      doBurst(n, 1'b1, base);
      base += n;
      rem -= n;
    end
    tick(2);
    checkEq("R8 validate on full packet", validCount, valBefore + 1);
    checkEq("R8 validated length", lastValidLen, MAX_PKT);
  endtask

  initial begin
    int wcBefore, vcBefore;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    checkEq("R1 dmaReq", int'(dmaReq), 0);
    checkEq("R1 cfgRdData", int'(cfgRdData), 0);
    checkEq("R1 eotFlag", int'(eotFlag), 0);
    checkEq("R1 validate/release/strobe", int'({bufValidate, bufRelease, bufWrStrobe}), 0);
    checkEq("R1 bufAddr", int'(bufAddr), 2);

    // R2 readback of every field, spare bits included
    writeCfg(8'hA7);
    checkEq("R2 readback", int'(cfgRdData), 8'hA7);
    tick(4);
    checkEq("R3 no request with buffer not full", int'(dmaReq), 0);
    writeCfg(8'h00);

    // R3 ready and enable gating, then drain that packet
    bufLen = CW'(4);
    fillPulse = 1'b1;
    tick(1);
    fillPulse = 1'b0;
    tick(6);
    checkEq("R3 no request while disabled", int'(dmaReq), 0);
    bufFull = 1'b0;
    writeCfg(8'h14);
    tick(6);
    checkEq("R3 no request while buffer not ready", int'(dmaReq), 0);
    writeCfg(8'h00);

    // R4 R6 R7 read sweep: every burst code, every packet length
    for (int code = 0; code < 4; code++) begin
      writeCfg(8'(8'h14 | code));
      for (int len = 1; len <= MAX_PKT; len++) begin
        readPacket(code, len);
        tick(4);
        checkEq("R3 idle once buffer drained", int'(dmaReq), 0);
      end
      // R11 auto-reload keeps enable after each packet
      checkEq("R11 enable kept with reload", int'(cfgRdData[2]), 1);
      writeCfg(8'h00);
    end

    // R4 R6 R8 write sweep
    bufEmpty = 1'b1;
    for (int code = 0; code < 4; code++) begin
      writeCfg(8'(8'h1C | code));
      writePacket(code, 17 * code + 3);
      writePacket(code, 29 * code + 101);
      writeCfg(8'h00);
      tick(4);
    end

    // R5 wrong strobe and missing acknowledge are not counted
    writeCfg(8'h1C);
    waitReq();
    wcBefore = wrCount;
    dmaAck_n = 1'b0;
    tick(2);
    rd_n = 1'b0;
    tick(4);
    rd_n = 1'b1;
    tick(4);
    dmaAck_n = 1'b1;
    tick(2);
    checkEq("R5 read strobe ignored in write direction", wrCount, wcBefore);
    checkEq("R5 offset unchanged after read strobe", int'(bufAddr), 2);
    checkEq("R5 request kept", int'(dmaReq), 1);
    dmaDataIn = 8'h5A;
    wr_n = 1'b0;
    tick(4);
    wr_n = 1'b1;
    tick(4);
    checkEq("R5 strobe without acknowledge ignored", wrCount, wcBefore);
    checkEq("R5 offset unchanged without acknowledge", int'(bufAddr), 2);
    checkEq("R5 request kept without acknowledge", int'(dmaReq), 1);
    writeCfg(8'h00);

    // R9 R10 early end of a write packet, flag read in the same cycle
    writeCfg(8'h1F);
    wrSeed = 77;
    vcBefore = validCount;
    waitReq();
    dmaAck_n = 1'b0;
    tick(2);
    for (int i = 0; i < 3; i++) begin
      dmaDataIn = 8'(wrVal(i));
      wr_n = 1'b0;
      tick(4);
      wr_n = 1'b1;
      tick(4);
    end
    eot_n = 1'b0;
    tick(2);
    irqRead = 1'b1;
    tick(1);
    irqRead = 1'b0;
    tick(3);
    checkEq("R9 request forced low", int'(dmaReq), 0);
    checkEq("R9 short packet validated", validCount, vcBefore + 1);
    checkEq("R9 short packet length", lastValidLen, 3);
    checkEq("R10 set wins over read", int'(eotFlag), 1);
    checkEq("R9 enable cleared", int'(cfgRdData), 8'h1B);
    checkEq("R9 count restarted", int'(bufAddr), 2);
    eot_n = 1'b1;
    dmaAck_n = 1'b1;
    tick(4);
    checkEq("R9 stays idle after end of transfer", int'(dmaReq), 0);
    irqRead = 1'b1;
    tick(1);
    irqRead = 1'b0;
    tick(2);
    checkEq("R10 read clears flag", int'(eotFlag), 0);
    writeCfg(8'h00);
    bufEmpty = 1'b0;

    // R11 without auto-reload the engine disables itself
    writeCfg(8'h05);
    readPacket(1, 3);
    tick(2);
    checkEq("R11 enable cleared without reload", int'(cfgRdData), 8'h01);
    fillPulse = 1'b1;
    tick(1);
    fillPulse = 1'b0;
    tick(8);
    checkEq("R11 no request after self-disable", int'(dmaReq), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule